// File: doc/BRIEF.md
# Wraparound Burst Offset Generator

This block supplies the low-order offset bits of a four-beat burst. When an access begins, the block captures the low bits of the start address. It then steps through the remaining beats, one beat for each advance pulse. The count wraps, so the fourth beat is followed by the start offset again. Logic outside the block keeps the upper address bits. It joins them to this block's offset to form the address presented to storage.

Two beat orders are available. In linear order, each beat adds one (modulo four) to the previous offset. In interleaved order, each offset is the start offset XORed with the beat number. The order-select input should be tied high when left unused, so that an unconnected select gives the interleaved order. A last-beat flag marks the fourth beat of the burst. A downstream controller can use it to end or restart the access.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, `ofs_o` is 0 and `last_o` is 0. After `rst_n` rises, the block ignores `load_i` and `adv_i` on the first two rising edges and acts on them from the third edge onward.
- R2: When `load_i` is high at a rising edge, `ofs_o` equals the sampled `start_ofs_i` after that edge, in either order, and the beat number returns to 0.
- R3: With `order_i` = 0 (linear), each advance makes `ofs_o` equal to the previous `ofs_o` plus 1, modulo 4. From starts 0, 1, 2 and 3 the bursts are 0-1-2-3, 1-2-3-0, 2-3-0-1 and 3-0-1-2.
- R4: With `order_i` = 1 (interleaved), `ofs_o` equals the start offset XOR the beat number. From starts 0, 1, 2 and 3 the bursts are 0-1-2-3, 1-0-3-2, 2-3-0-1 and 3-2-1-0.
- R5: When neither `load_i` nor `adv_i` is high at an edge, the beat number and `ofs_o` hold (with `order_i` unchanged).
- R6: When `load_i` and `adv_i` are both high at one edge, the load wins. `ofs_o` shows the new start offset, not an advanced one.
- R7: `last_o` is 1 exactly when the beat number is 3, the fourth beat, and 0 on beats 0 to 2.
- R8: An advance on the fourth beat wraps the beat number to 0. `ofs_o` returns to the start offset and `last_o` falls.
- R9: `order_i` is applied combinationally to the current beat. Changing it mid-burst remaps `ofs_o` at once and leaves the beat number unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released synchronously |
| load_i | input | 1 | Begin a new burst at `start_ofs_i` |
| start_ofs_i | input | OFS_W (2) | Low bits of the burst start address |
| adv_i | input | 1 | Step to the next beat |
| order_i | input | 1 | 0 = linear order, 1 = interleaved order (tie high by default) |
| ofs_o | output | OFS_W (2) | Current burst offset |
| last_o | output | 1 | High on the fourth beat |

## Verification
Load and advance can be sampled at the same edge. That collision is where the priority rule decides the outcome. The stimulus raises both inputs together on many edges, in directed steps and in the random phase. After such an edge, the offset must equal the newly loaded start with the beat restarted at zero. A stepped value means the advance was wrongly taken. A second overlap happens when an advance lands on the fourth beat while the order select changes. Here the reference model checks that the wrap and the remap combine correctly.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_rst_sync.sv
// Asynchronous assertion, two-stage synchronous release.
module burst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/burst_beat_ctr.sv
// Holds the captured start offset and the wrapping beat number.
module burst_beat_ctr #(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [OFS_W-1:0] start_i,
  output logic [OFS_W-1:0] start_o,
  output logic [OFS_W-1:0] beat_o
);
  logic [OFS_W-1:0] start_q, start_d;
  logic [OFS_W-1:0] beat_q,  beat_d;
  logic             start_en, beat_en;

  always_comb begin
    start_en = load_i;
    beat_en  = load_i | adv_i;
    start_d  = start_i;
    if (load_i) beat_d = '0;                    // load has priority
    else        beat_d = beat_q + OFS_W'(1);    // natural wrap
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      beat_q  <= '0;
    end else begin
      if (start_en) start_q <= start_d;
      if (beat_en)  beat_q  <= beat_d;
    end
  end

  assign start_o = start_q;
  assign beat_o  = beat_q;
endmodule

// File: rtl/burst_ofs_map.sv
// Maps start offset and beat number to the visible offset.
module burst_ofs_map #(
  parameter int OFS_W = 2
) (
  input  logic                    order_i,
  input  logic [OFS_W-1:0]        start_i,
  input  logic [OFS_W-1:0]        beat_i,
  output logic [OFS_W-1:0]        ofs_o
);
  import burst_pkg::*;
  logic [OFS_W-1:0] lin_ofs;
  logic [OFS_W-1:0] ilv_ofs;

  always_comb begin
    lin_ofs = start_i + beat_i;
  end

  for (genvar b = 0; b < OFS_W; b++) begin : g_ilv
    assign ilv_ofs[b] = start_i[b] ^ beat_i[b];
  end

  always_comb begin
    if (burst_order_e'(order_i) == ORD_INTERLEAVE) ofs_o = ilv_ofs;
    else                                           ofs_o = lin_ofs;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [OFS_W-1:0] start_ofs_i,
  input  logic             adv_i,
  input  logic             order_i,
  output logic [OFS_W-1:0] ofs_o,
  output logic             last_o
);
  localparam logic [OFS_W-1:0] LAST_BEAT = {OFS_W{1'b1}};

  logic             rst_int_n;
  logic [OFS_W-1:0] start_q;
  logic [OFS_W-1:0] beat_q;

  burst_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  burst_beat_ctr #(.OFS_W(OFS_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_i  (load_i),
    .adv_i   (adv_i),
    .start_i (start_ofs_i),
    .start_o (start_q),
    .beat_o  (beat_q)
  );

  burst_ofs_map #(.OFS_W(OFS_W)) u_map (
    .order_i (order_i),
    .start_i (start_q),
    .beat_i  (beat_q),
    .ofs_o   (ofs_o)
  );

  assign last_o = (beat_q == LAST_BEAT);
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int OFS_W = 2
) (
  input logic             clk,
  input logic             rst_int_n,
  input logic             load_i,
  input logic [OFS_W-1:0] start_ofs_i,
  input logic             adv_i,
  input logic             order_i,
  input logic [OFS_W-1:0] ofs_o,
  input logic             last_o,
  input logic [OFS_W-1:0] beat_q
);
  p_rst_clear_r1: assert property (@(posedge clk)
    !rst_int_n |-> (ofs_o == '0 && !last_o));

  p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    load_i |=> (ofs_o == $past(start_ofs_i) && beat_q == '0));

  p_lin_step_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (adv_i && !load_i && !order_i) ##1 !order_i |-> ofs_o == OFS_W'($past(ofs_o) + 1));

  p_ilv_step_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (adv_i && !load_i && order_i) ##1 order_i |-> (ofs_o ^ $past(ofs_o)) == (beat_q ^ $past(beat_q)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!load_i && !adv_i) |=> $stable(beat_q));

  p_load_wins_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (load_i && adv_i) |=> !last_o);

  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (adv_i && !load_i && last_o) |=> (beat_q == '0 && !last_o));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.OFS_W(OFS_W)) u_chk (
  .clk         (clk),
  .rst_int_n   (rst_int_n),
  .load_i      (load_i),
  .start_ofs_i (start_ofs_i),
  .adv_i       (adv_i),
  .order_i     (order_i),
  .ofs_o       (ofs_o),
  .last_o      (last_o),
  .beat_q      (beat_q)
);

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  logic       clk;
  logic       rst_n;
  logic       load_i;
  logic [1:0] start_ofs_i;
  logic       adv_i;
  logic       order_i;
  logic [1:0] ofs_o;
  logic       last_o;

  int tests = 0;
  int fails = 0;

  logic [1:0] m_start;
  logic [1:0] m_beat;

  burst_addr_gen #(.OFS_W(2)) u0 (
    .clk, .rst_n, .load_i, .start_ofs_i, .adv_i, .order_i, .ofs_o, .last_o
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [1:0] exp_ofs(logic [1:0] s, logic [1:0] b, logic ord);
    return ord ? (s ^ b) : 2'(s + b);
  endfunction

  task automatic check(string req);
    logic [1:0] e_ofs;
    logic       e_last;
    e_ofs  = exp_ofs(m_start, m_beat, order_i);
    e_last = (m_beat == 2'd3);
    tests++;
    if (ofs_o !== e_ofs || last_o !== e_last) begin
      fails++;
      $display("FAIL %s: ofs=%0d last=%0b expected ofs=%0d last=%0b",
               req, ofs_o, last_o, e_ofs, e_last);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
  task automatic step(logic ld, logic [1:0] st, logic ad, logic ord, string req);
    load_i = ld; start_ofs_i = st; adv_i = ad; order_i = ord;
    if (ld) begin m_start = st; m_beat = 2'd0; end
    else if (ad) m_beat = m_beat + 2'd1;
    @(negedge clk);
    check(req);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_i = 1'b0; start_ofs_i = 2'd0; adv_i = 1'b0; order_i = 1'b1;
    m_start = 2'd0; m_beat = 2'd0;
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    check("R1 reset");
    // R1: loads during the two release edges are ignored
    rst_n = 1'b1;
    load_i = 1'b1; start_ofs_i = 2'd3; adv_i = 1'b1;
    @(negedge clk);
    load_i = 1'b1; start_ofs_i = 2'd2;
    @(negedge clk);
    load_i = 1'b0; adv_i = 1'b0;
    check("R1 release");
    @(negedge clk);
    check("R1 idle");

    // R3 linear and R4 interleaved tables, all starts, with R7 last flag and R8 wrap
    for (int ord = 0; ord < 2; ord++) begin
      for (int s = 0; s < 4; s++) begin
        step(1'b1, 2'(s), 1'b0, 1'(ord), ord ? "R2 R4 load" : "R2 R3 load");
        for (int k = 0; k < 3; k++)
          step(1'b0, 2'd0, 1'b1, 1'(ord), ord ? "R4 R7 interleaved beat" : "R3 R7 linear beat");
        step(1'b0, 2'd0, 1'b1, 1'(ord), "R8 wrap");
      end
    end

    // R5 hold
    step(1'b1, 2'd1, 1'b0, 1'b0, "R2 load");
    step(1'b0, 2'd0, 1'b1, 1'b0, "R3 step");
    repeat (3) step(1'b0, 2'd3, 1'b0, 1'b0, "R5 hold");

    // R6 load and advance together, including on the last beat
    step(1'b0, 2'd0, 1'b1, 1'b0, "R3 step");
    step(1'b0, 2'd0, 1'b1, 1'b0, "R7 last");
    step(1'b1, 2'd2, 1'b1, 1'b0, "R6 load wins");
    step(1'b1, 2'd1, 1'b1, 1'b1, "R6 load wins interleaved");

    // R9 order switch mid-burst
    step(1'b0, 2'd0, 1'b1, 1'b1, "R4 step");
    step(1'b0, 2'd0, 1'b0, 1'b0, "R9 remap to linear");
    step(1'b0, 2'd0, 1'b0, 1'b1, "R9 remap to interleaved");

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      logic ld, ad, od;
      logic [1:0] st;
      ld = ($urandom % 4) == 0;
      ad = ($urandom % 3) != 0;
      od = (($urandom % 16) == 0) ? ~order_i : order_i;
      st = 2'($urandom);
      if (ld && ad)       step(ld, st, ad, od, "R6 random");
      else if (ld)        step(ld, st, ad, od, "R2 random");
      else if (!ad)       step(ld, st, ad, od, "R5 random");
      else if (m_beat == 2'd3) step(ld, st, ad, od, "R8 random");
      else                step(ld, st, ad, od, od ? "R4 random" : "R3 random");
    end

    // R1 asynchronous reset mid-burst
    step(1'b1, 2'd3, 1'b0, 1'b0, "R2 load");
    #3 rst_n = 1'b0;
    m_start = 2'd0; m_beat = 2'd0;
    #2 check("R1 async clear");
    @(negedge clk);
    check("R1 held");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule